// File: doc/BRIEF.md
# Two-Bank Level Interrupt Mask Controller

This block collects up to 64 level-sensitive interrupt requests from peripherals and presents them to a processor core on two request lines. One is a normal request and one is a fast request. The sources are grouped into banks of 32. Each bank has an enable word and a steering word. The enable word gates each source. The steering word sends each enabled source to the normal line or to the fast line. A single qualifier bit selects how the wake output behaves: it is raised either by any pending source, or only by pending sources that are enabled.

Software configures the block through a small word-addressed register port. Writes are single-cycle and reads are combinational. Sources are never latched inside the block. To acknowledge a source, software clears its enable bit, and the request persists for as long as the peripheral holds its line high. Every source input is sampled into a register once per clock. All three outputs are driven from that sampled state and from the configuration registers, so each output follows a change on a source input after exactly one clock edge.

Top module: `dual_bank_intc`

## Requirements
- R1: After synchronous reset, every enable bit, steering bit and the qualifier bit is 0, every register reads 0 while the sources are low, and irq_o, fiq_o and wake_o are low.
- R2: Register word addresses: bank b uses word 4*b+0 for enable, 4*b+1 for steering and 4*b+2 for pending. Bit k of each bank word belongs to that bank's source k. Word 4*NUM_BANKS holds the wake qualifier in bit 0. A write to an enable, steering or qualifier word takes effect on the next clock edge.
- R3: Source n drives bank n/32, bit n%32. Bank 1 is controlled only by its own words, at addresses 4 to 6.
- R4: irq_o is high when at least one sampled source is high, enabled, and has a steering bit of 0. It reacts one clock edge after a source input changes.
- R5: fiq_o is high when at least one sampled source is high, enabled, and has a steering bit of 1. A source steered to the fast line never raises irq_o.
- R6: A change of an enable or steering bit shows on irq_o and fiq_o right after the clock edge that accepts the write, and not before it.
- R7: Clearing an enable bit removes that source from the outputs while its line stays high. Setting the bit again while the line is still high raises the output again. Lowering the line drops the output.
- R8: The pending word of each bank reads the sampled source levels ANDed with that bank's enable word.
- R9: With the qualifier bit at 1, wake_o is high only when some enabled source is high.
- R10: With the qualifier bit at 0, wake_o is high when any sampled source is high, whether enabled or not.
- R11: Writes to pending words and to unused addresses change nothing. Unused addresses read 0, and the qualifier word reads 0 in bits 31 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| src_lvl | input | 64 | Peripheral request levels, bit n is source n |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle wake request |

## Verification
A corrupted enable or steering bit shows up after one clock edge. Its source then lands on the wrong request line, or on no line at all, and the same error appears in that bank's pending word. A stuck sampling register shows as a one-edge delay that is missing or too long on irq_o and fiq_o. A qualifier bit that holds the wrong value shows on wake_o as soon as a disabled source is driven high. The bench drives a single source at a time in both banks, so a bank or bit index that is swapped is visible at once.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DEF_BANKS  = 2;
    localparam int DEF_BANK_W = 32;
    localparam int DEF_ADDR_W = 4;

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_STEER  = 2'd1,
        REG_PEND   = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic irq_hit;
        logic fiq_hit;
        logic any_lvl;
    } bank_sum_t;

    function automatic bank_sum_t summarize(input logic any_irq, input logic any_fiq,
                                            input logic any_raw);
        bank_sum_t s;
        s.irq_hit = any_irq;
        s.fiq_hit = any_fiq;
        s.any_lvl = any_raw;
        return s;
    endfunction

endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_we,
    input  logic              steer_we,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] lvl_q,
    output logic [BANK_W-1:0] enable_q,
    output logic [BANK_W-1:0] steer_q,
    output logic [BANK_W-1:0] pend,
    output bank_sum_t         sum
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            steer_q  <= '0;
        end else begin
            if (en_we)    enable_q <= wdata;
            if (steer_we) steer_q  <= wdata;
        end
    end

    assign pend = lvl_q & enable_q;

    always_comb begin
        sum = summarize(|(pend & ~steer_q), |(pend & steer_q), |lvl_q);
    end

    // R6: accepted enable write is visible after the edge
    a_r6_enable_write: assert property (@(posedge clk) disable iff (rst)
        en_we |=> (enable_q == $past(wdata)));

    // R7: clearing every enable bit silences the bank on the next cycle
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (en_we && wdata == '0) |=> (!sum.irq_hit && !sum.fiq_hit));

    // R5: a fully fast-steered bank never feeds the normal line
    a_r5_fast_only: assert property (@(posedge clk) disable iff (rst)
        (steer_q == '1) |-> !sum.irq_hit);

endmodule

// File: rtl/irqc_out.sv
module irqc_out
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           qual_we,
    input  logic                           qual_wbit,
    input  bank_sum_t [NUM_BANKS-1:0]      sums,
    output logic                           qual_q,
    output logic                           irq_o,
    output logic                           fiq_o,
    output logic                           wake_o
);

    logic any_irq, any_fiq, any_raw;

    always_ff @(posedge clk) begin
        if (rst)          qual_q <= 1'b0;
        else if (qual_we) qual_q <= qual_wbit;
    end

    always_comb begin
        any_irq = 1'b0;
        any_fiq = 1'b0;
        any_raw = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            any_irq = any_irq | sums[b].irq_hit;
            any_fiq = any_fiq | sums[b].fiq_hit;
            any_raw = any_raw | sums[b].any_lvl;
        end
    end

    assign irq_o  = any_irq;
    assign fiq_o  = any_fiq;
    assign wake_o = qual_q ? (any_irq | any_fiq) : any_raw;

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = irqc_pkg::DEF_BANKS,
    parameter int BANK_W    = irqc_pkg::DEF_BANK_W,
    parameter int ADDR_W    = irqc_pkg::DEF_ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] src_lvl,
    output logic                        irq_o,
    output logic                        fiq_o,
    output logic                        wake_o
);

    localparam int SRC_W  = NUM_BANKS * BANK_W;
    localparam int IDX_W  = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] QUAL_ADDR = ADDR_W'(NUM_BANKS * 4);

    logic [SRC_W-1:0]               lvl_q;
    logic [NUM_BANKS-1:0][BANK_W-1:0] enable_w, steer_w, pend_w, rd_w;
    bank_sum_t [NUM_BANKS-1:0]      sums;
    logic                           qual_q;
    reg_sel_e                       sel;
    logic [IDX_W-1:0]               idx;

    assign sel = reg_sel_e'(bus_addr[1:0]);
    assign idx = bus_addr[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= src_lvl;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (idx == IDX_W'(b));

        irqc_bank #(.BANK_W(BANK_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .en_we    (bus_we && hit && sel == REG_ENABLE),
            .steer_we (bus_we && hit && sel == REG_STEER),
            .wdata    (bus_wdata),
            .lvl_q    (lvl_q[b*BANK_W +: BANK_W]),
            .enable_q (enable_w[b]),
            .steer_q  (steer_w[b]),
            .pend     (pend_w[b]),
            .sum      (sums[b])
        );

        always_comb begin
            rd_w[b] = '0;
            if (hit) begin
                case (sel)
                    REG_ENABLE: rd_w[b] = enable_w[b];
                    REG_STEER:  rd_w[b] = steer_w[b];
                    REG_PEND:   rd_w[b] = pend_w[b];
                    default:    rd_w[b] = '0;
                endcase
            end
        end
    end

    irqc_out #(.NUM_BANKS(NUM_BANKS)) u_out (
        .clk       (clk),
        .rst       (rst),
        .qual_we   (bus_we && bus_addr == QUAL_ADDR),
        .qual_wbit (bus_wdata[0]),
        .sums      (sums),
        .qual_q    (qual_q),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o),
        .wake_o    (wake_o)
    );

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) bus_rdata = bus_rdata | rd_w[b];
        if (bus_addr == QUAL_ADDR) bus_rdata = {{(BANK_W-1){1'b0}}, qual_q};
    end

    // R1: outputs quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_o && !fiq_o));

    // R9: qualified wake needs an enabled high source
    a_r9_qual_wake: assert property (@(posedge clk) disable iff (rst)
        (qual_q && wake_o) |-> (|(pend_w)));

    // R10: unqualified wake follows any sampled level
    a_r10_raw_wake: assert property (@(posedge clk) disable iff (rst)
        (!qual_q && (|lvl_q)) |-> wake_o);

endmodule

// File: tb/dual_bank_intc_bench.sv
module dual_bank_intc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_lvl = '0;
    logic        irq_o, fiq_o, wake_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dual_bank_intc u_dual_bank_intc (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src_lvl = v;
        @(negedge clk);
        #2;
    endtask

    task automatic clear_all();
        wr(4'd0, '0); wr(4'd1, '0); wr(4'd4, '0); wr(4'd5, '0); wr(4'd8, '0);
        set_src('0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        foreach (d[i]) ;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check("R1 reg read", d, 0);
        end
        check("R1 irq", irq_o, 0);
        check("R1 fiq", fiq_o, 0);
        check("R1 wake", wake_o, 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(4'd0, 32'hA5A5_0F0F);
        wr(4'd5, 32'h1234_5678);
        rd(4'd0, d); check("R2 bank0 enable", d, 32'hA5A5_0F0F);
        rd(4'd5, d); check("R2 bank1 steer", d, 32'h1234_5678);
        rd(4'd4, d); check("R3 bank1 enable separate", d, 0);
        rd(4'd1, d); check("R3 bank0 steer separate", d, 0);
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd0, d); check("R11 pend write ignored", d, 32'hA5A5_0F0F);
        rd(4'd2, d); check("R11 pend unchanged", d, 0);
        rd(4'd3, d); check("R11 spare reads zero", d, 0);
        rd(4'd12, d); check("R11 unused reads zero", d, 0);
        wr(4'd8, 32'hFFFF_FFFE);
        rd(4'd8, d); check("R11 qual bit0 only", d, 0);
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd8, d); check("R2 qual readback", d, 1);
        clear_all();
    endtask

    task automatic t_route();
        wr(4'd4, 32'h0000_0100);
        @(negedge clk);
        src_lvl = 64'h1 << 40;
        #8 check("R4 no change before edge", irq_o, 0);
        @(negedge clk); #2;
        check("R4 irq after one edge", irq_o, 1);
        check("R3 source 40 via bank1", fiq_o, 0);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'd5; bus_wdata = 32'h0000_0100;
        #8 check("R6 steer not yet applied", irq_o, 1);
        @(negedge clk); bus_we = 1'b0; #2;
        check("R6 irq drops after edge", irq_o, 0);
        check("R5 fiq raised", fiq_o, 1);
        set_src((64'h1 << 40) | (64'h1 << 3));
        check("R4 unenabled bank0 src no irq", irq_o, 0);
        wr(4'd0, 32'h0000_0008);
        #2 check("R5 both lines", {irq_o, fiq_o}, 2'b11);
        clear_all();
    endtask

    task automatic t_ack();
        wr(4'd0, 32'h8000_0000);
        set_src(64'h8000_0000);
        check("R7 irq with source", irq_o, 1);
        wr(4'd0, 32'h0);
        #2 check("R7 ack by clearing enable", irq_o, 0);
        wr(4'd0, 32'h8000_0000);
        #2 check("R7 level still pending", irq_o, 1);
        set_src('0);
        check("R7 drops with line", irq_o, 0);
        clear_all();
    endtask

    task automatic t_pend();
        logic [31:0] d;
        wr(4'd0, 32'hFF00_FF00);
        wr(4'd4, 32'h0F0F_0F0F);
        set_src(64'h3C3C_3C3C_F0F0_F0F0);
        rd(4'd2, d); check("R8 bank0 pending", d, 32'hF000_F000);
        rd(4'd6, d); check("R8 bank1 pending", d, 32'h0C0C_0C0C);
        clear_all();
    endtask

    task automatic t_wake();
        set_src(64'h1 << 63);
        check("R10 any level wakes", wake_o, 1);
        check("R10 no irq when disabled", irq_o, 0);
        wr(4'd8, 32'h1);
        #2 check("R9 disabled source no wake", wake_o, 0);
        wr(4'd4, 32'h8000_0000);
        #2 check("R9 enabled source wakes", wake_o, 1);
        wr(4'd5, 32'h8000_0000);
        #2 check("R9 fast-steered wakes", wake_o, 1);
        set_src('0);
        check("R9 no source no wake", wake_o, 0);
        clear_all();
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_route();
        t_ack();
        t_pend();
        t_wake();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule